// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous dynamic RAM whose address pins are shared between row and column. The host presents a 17-bit word address, a write flag and a byte of write data over a valid/ready handshake. The controller splits the address into an 8-bit row and a 9-bit column and produces the four active-low strobes. These are row strobe, column strobe, write strobe and output enable. It also drives a 9-bit multiplexed address and a split data path: data out, data in and a drive enable.

Once a row is opened, it stays open. A later request to the same row becomes a column-only cycle with no new row strobe. A request to a different row first precharges and then opens the new row. Every analog timing limit is expressed as a count of clock cycles set by a parameter. A row that has been open for a parameterised number of cycles is closed while the controller is idle.

Refresh is scheduled elsewhere. The controller only closes its row and then grants the refresh request.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and right after reset, all four strobes are high, the data drive enable is 0, the refresh grant is 0, read-valid is 0 and ready is 1.
- R2: The row field is request address bits [16:9] and is driven on address pins [7:0] with pin 8 at 0 when the row strobe falls. The column field is bits [8:0] and is on all nine pins when the column strobe falls.
- R3: When a row is opened, the column strobe falls exactly T_RCD cycles after the row strobe falls, and only while the row strobe is low.
- R4: The column strobe stays low exactly T_CAS cycles per access. Between two accesses in the same row it is high for at least T_CP cycles.
- R5: For a write, the write strobe is low and the data drive enable is 1, carrying the request data, in the cycle the column strobe falls (early write).
- R6: For a read, output enable is low while the column strobe is low and the data drive enable is 0. Data in is captured on the last low cycle of the column strobe and returned with a one-cycle read-valid pulse, in request order.
- R7: A request whose row equals the open row is served without any row strobe transition.
- R8: A request to a different row raises the row strobe, then lowers it again with the new row.
- R9: The row strobe is never low longer than ROW_OPEN_MAX + T_CAS + T_CP + 2 cycles. An idle open row is closed.
- R10: A refresh request closes any open row. The grant is given only while both strobes are high, and held until the request drops. Ready is 0 while the request is high.
- R11: The row strobe is high for at least T_RP cycles before every fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address, row in [16:9], column in [8:0] |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Read data |
| ref_req | input | 1 | External refresh request |
| ref_gnt | output | 1 | Refresh grant, DRAM idle |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed address |
| dram_dq_out | output | 8 | Data to DRAM |
| dram_dq_oe | output | 1 | Drive enable for data to DRAM |
| dram_dq_in | input | 8 | Data from DRAM |

## Verification
Directed sequences separate the three access paths. An access from a closed row, a same-row access and a different-row access each give a distinct count of row strobe falls and a distinct strobe spacing. A random mix confined to four rows with random columns and directions then produces long hit runs broken by misses, interleaved with refresh handshakes. Read-back data compared against a bench memory model shows whether row and column fields are routed and latched correctly. A long idle gap with a row open, and a refresh raised while a row is open, show the forced-close paths.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_COL,
    ST_CPRE,
    ST_OPEN,
    ST_PRE,
    ST_REFG
  } fpm_state_e;
endpackage

// File: rtl/fpm_wait.sv
module fpm_wait #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fpm_page_track.sv
module fpm_page_track #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_set,
  input  logic             close,
  input  logic [ROW_W-1:0] row_in,
  output logic             row_open,
  output logic [ROW_W-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      row_open <= 1'b0;
      row_q    <= '0;
    end else if (open_set) begin
      row_open <= 1'b1;
      row_q    <= row_in;
    end else if (close) begin
      row_open <= 1'b0;
    end
  end

  // R8
  open_close_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(open_set && close));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W        = 8,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 8,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 1,
  parameter int ROW_OPEN_MAX = 12000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    ref_req,
  output logic                    ref_gnt,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_we_n,
  output logic                    dram_oe_n,
  output logic [((COL_W > ROW_W) ? COL_W : ROW_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);
  localparam int PIN_W = (COL_W > ROW_W) ? COL_W : ROW_W;
  localparam int TMAX1 = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TMAX2 = (T_CAS > T_CP) ? T_CAS : T_CP;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int AW    = $clog2(ROW_OPEN_MAX + 1);

  fpm_state_e state, nxt;

  logic [ROW_W-1:0]  req_row, pend_row, row_src, open_row;
  logic [COL_W-1:0]  req_col, pend_col, col_src;
  logic [DATA_W-1:0] pend_data, data_src;
  logic              pend_write, pend_vld, wr_src;
  logic              accept, hit, row_open;
  logic              tm_load, tm_done, age_done, open_set, close_row;
  logic [TW-1:0]     tm_val;

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN && !age_done)) && !ref_req;
  assign accept    = req_valid && req_ready;
  assign hit       = row_open && (req_row == open_row);

  assign row_src  = (state == ST_PRE)  ? pend_row  : req_row;
  assign col_src  = (state == ST_OPEN) ? req_col   : pend_col;
  assign data_src = (state == ST_OPEN) ? req_wdata : pend_data;
  assign wr_src   = (state == ST_OPEN) ? req_write : pend_write;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (ref_req) nxt = ST_REFG; else if (accept) nxt = ST_ACT;
      ST_ACT:  if (tm_done) nxt = ST_COL;
      ST_COL:  if (tm_done) nxt = ST_CPRE;
      ST_CPRE: if (tm_done) nxt = ST_OPEN;
      ST_OPEN: if (ref_req || age_done) nxt = ST_PRE;
               else if (accept) nxt = hit ? ST_COL : ST_PRE;
      ST_PRE:  if (tm_done) nxt = pend_vld ? ST_ACT : ST_IDLE;
      ST_REFG: if (!ref_req) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    tm_load = (nxt != state);
    case (nxt)
      ST_ACT:  tm_val = TW'(T_RCD - 1);
      ST_COL:  tm_val = TW'(T_CAS - 1);
      ST_CPRE: tm_val = TW'(T_CP - 1);
      ST_PRE:  tm_val = TW'(T_RP - 1);
      default: tm_val = '0;
    endcase
  end

  assign open_set  = (nxt == ST_ACT) && (state != ST_ACT);
  assign close_row = (nxt == ST_PRE) && (state != ST_PRE);

  fpm_wait #(.W(TW)) phase_tmr (
    .clk(clk), .rst(rst), .load(tm_load), .val(tm_val), .done(tm_done)
  );

  fpm_wait #(.W(AW)) age_tmr (
    .clk(clk), .rst(rst), .load(open_set), .val(AW'(ROW_OPEN_MAX - 1)), .done(age_done)
  );

  fpm_page_track #(.ROW_W(ROW_W)) page_i (
    .clk(clk), .rst(rst), .open_set(open_set), .close(close_row),
    .row_in(row_src), .row_open(row_open), .row_q(open_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pend_vld    <= 1'b0;
      pend_write  <= 1'b0;
      pend_row    <= '0;
      pend_col    <= '0;
      pend_data   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      ref_gnt     <= 1'b0;
    end else begin
      state    <= nxt;
      rd_valid <= 1'b0;
      if (accept) begin
        pend_write <= req_write;
        pend_row   <= req_row;
        pend_col   <= req_col;
        pend_data  <= req_wdata;
      end
      if (state == ST_OPEN && accept && !hit && !ref_req && !age_done) pend_vld <= 1'b1;
      if (state == ST_PRE && nxt == ST_ACT) pend_vld <= 1'b0;
      if (open_set) begin
        dram_ras_n <= 1'b0;
        dram_addr  <= PIN_W'(row_src);
      end
      if (nxt == ST_COL && state != ST_COL) begin
        dram_cas_n  <= 1'b0;
        dram_addr   <= PIN_W'(col_src);
        dram_we_n   <= ~wr_src;
        dram_oe_n   <= wr_src;
        dram_dq_out <= data_src;
        dram_dq_oe  <= wr_src;
      end
      if (state == ST_COL && nxt == ST_CPRE) begin
        dram_cas_n <= 1'b1;
        dram_oe_n  <= 1'b1;
        if (!pend_write) begin
          rd_data  <= dram_dq_in;
          rd_valid <= 1'b1;
        end
      end
      if (state == ST_CPRE && nxt == ST_OPEN) begin
        dram_we_n  <= 1'b1;
        dram_dq_oe <= 1'b0;
      end
      if (close_row) dram_ras_n <= 1'b1;
      if (nxt == ST_REFG && state != ST_REFG) ref_gnt <= 1'b1;
      if (state == ST_REFG && nxt != ST_REFG) ref_gnt <= 1'b0;
    end
  end

  // Strobe width counters for the checks below
  logic [15:0] chk_cas_lo, chk_ras_hi;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_cas_lo <= '0;
      chk_ras_hi <= 16'(T_RP);
    end else begin
      chk_cas_lo <= dram_cas_n ? 16'd0 : ((chk_cas_lo == 16'hFFFF) ? chk_cas_lo : chk_cas_lo + 16'd1);
      chk_ras_hi <= !dram_ras_n ? 16'd0 : ((chk_ras_hi == 16'hFFFF) ? chk_ras_hi : chk_ras_hi + 16'd1);
    end
  end

  // R4
  cas_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas_n) |-> (chk_cas_lo == 16'(T_CAS)));
  // R11
  ras_precharge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (chk_ras_hi >= 16'(T_RP)));
  // R3
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> !dram_ras_n);
  // R5
  we_drives_data_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> dram_dq_oe);
  // R6
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
    !(!dram_oe_n && dram_dq_oe));
  // R10
  gnt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> (dram_ras_n && dram_cas_n));
  // R7
  hit_keeps_row_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPEN && accept && hit && !age_done) |=> (!dram_ras_n && !dram_cas_n));
endmodule

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_RP = 2, T_RCD = 2, T_CAS = 2, T_CP = 1, ROW_OPEN_MAX = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, dram_dq_in = '0;
  logic req_ready, rd_valid, ref_gnt, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0] rd_data, dram_dq_out;
  logic [8:0] dram_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_dram_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
                  .ROW_OPEN_MAX(ROW_OPEN_MAX)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] dmem [int];
  logic [7:0] smem [int];
  logic [7:0] expq [$];
  logic [7:0] last_row = '0;
  logic [8:0] last_col = '0;
  int n_ras_fall = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ref_read(input int key);
    return smem.exists(key) ? smem[key] : 8'h00;
  endfunction

  // DRAM model and timing monitor, sampled on the falling clock edge
  logic prev_ras = 1'b1, prev_cas = 1'b1, cas_in_row = 1'b0;
  logic [7:0] mrow = '0;
  int since_ras = 0, cas_lo = 0, cas_hi = 0, ras_hi = 100, ras_lo = 0;
  always @(negedge clk) begin
    if (!rst) begin
      since_ras++; cas_lo++; cas_hi++; ras_hi++; ras_lo++;
      if (prev_ras && !dram_ras_n) begin
        check(ras_hi >= T_RP, "R11 ras precharge", ras_hi, T_RP);
        check(dram_addr == {1'b0, last_row}, "R2 row on pins", dram_addr, {1'b0, last_row});
        mrow = dram_addr[7:0];
        since_ras = 0; ras_lo = 0; cas_in_row = 1'b0; n_ras_fall++;
      end
      if (!prev_ras && dram_ras_n) begin
        check(ras_lo <= ROW_OPEN_MAX + T_CAS + T_CP + 2, "R9 ras low length", ras_lo, ROW_OPEN_MAX);
        ras_hi = 0;
      end
      if (prev_cas && !dram_cas_n) begin
        if (!cas_in_row) check(since_ras == T_RCD, "R3 ras-to-cas", since_ras, T_RCD);
        else check(cas_hi >= T_CP, "R4 cas precharge", cas_hi, T_CP);
        check(dram_addr == last_col, "R2 col on pins", dram_addr, last_col);
        if (!dram_we_n) begin
          check(dram_dq_oe, "R5 data driven on write", dram_dq_oe, 1);
          dmem[{mrow, dram_addr}] = dram_dq_out;
        end
        if (!dram_oe_n) begin
          check(!dram_dq_oe, "R6 no drive on read", dram_dq_oe, 0);
          dram_dq_in = dmem.exists({mrow, dram_addr}) ? dmem[{mrow, dram_addr}] : 8'h00;
        end
        cas_in_row = 1'b1; cas_lo = 0;
      end
      if (!prev_cas && dram_cas_n) begin
        check(cas_lo == T_CAS, "R4 cas low width", cas_lo, T_CAS);
        cas_hi = 0;
      end
      if (ref_gnt) check(dram_ras_n && dram_cas_n, "R10 grant while idle", {dram_ras_n, dram_cas_n}, 3);
      if (rd_valid) begin
        if (expq.size() == 0) check(1'b0, "R6 unexpected rvalid", 1, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          check(rd_data == e, "R6 read data", rd_data, e);
        end
      end
      prev_ras = dram_ras_n; prev_cas = dram_cas_n;
    end
  end

  task automatic do_req(input bit wr, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    last_row = a[16:9]; last_col = a[8:0];
    if (wr) smem[int'(a)] = d;
    else expq.push_back(ref_read(int'(a)));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_refresh();
    int w;
    @(negedge clk);
    ref_req = 1'b1;
    w = 0;
    @(negedge clk);
    check(!req_ready, "R10 ready low during refresh", req_ready, 0);
    while (!ref_gnt && w < 30) begin @(negedge clk); w++; end
    check(ref_gnt, "R10 grant given", ref_gnt, 1);
    check(dram_ras_n, "R10 row closed at grant", dram_ras_n, 1);
    repeat (3) @(negedge clk);
    check(ref_gnt, "R10 grant held", ref_gnt, 1);
    ref_req = 1'b0;
    repeat (2) @(negedge clk);
    check(!ref_gnt, "R10 grant dropped", ref_gnt, 0);
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed, nr;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    @(negedge clk); rst = 1'b0;
    check(!dram_dq_oe && !ref_gnt && !rd_valid && req_ready, "R1 after reset",
          {dram_dq_oe, ref_gnt, rd_valid, req_ready}, 1);

    // Closed row write, then read back through the open row
    nr = n_ras_fall;
    do_req(1'b1, 17'h12345, 8'hA5);
    repeat (6) @(negedge clk);
    check(n_ras_fall == nr + 1, "R3 one row open", n_ras_fall, nr + 1);
    nr = n_ras_fall;
    do_req(1'b0, 17'h12345, 8'h00);
    do_req(1'b1, {8'h91, 9'h1FF}, 8'h3C);
    do_req(1'b0, {8'h91, 9'h1FF}, 8'h00);
    repeat (6) @(negedge clk);
    check(n_ras_fall == nr, "R7 hits keep row", n_ras_fall, nr);
    check(!dram_ras_n, "R7 row still open", dram_ras_n, 0);

    // Row change
    nr = n_ras_fall;
    do_req(1'b0, {8'h00, 9'h000}, 8'h00);
    do_req(1'b1, {8'hFF, 9'h155}, 8'h77);
    do_req(1'b0, {8'hFF, 9'h155}, 8'h00);
    repeat (8) @(negedge clk);
    check(n_ras_fall == nr + 2, "R8 two misses", n_ras_fall, nr + 2);

    // Idle timeout closes the row
    repeat (ROW_OPEN_MAX + 10) @(negedge clk);
    check(dram_ras_n, "R9 idle row closed", dram_ras_n, 1);
    check(req_ready, "R9 ready after close", req_ready, 1);

    // Refresh with a row open
    do_req(1'b1, {8'h10, 9'h010}, 8'h5A);
    repeat (5) @(negedge clk);
    check(!dram_ras_n, "R10 row open before refresh", dram_ras_n, 0);
    do_refresh();
    check(req_ready, "R10 ready after refresh", req_ready, 1);
    do_req(1'b0, {8'h10, 9'h010}, 8'h00);

    // Random mix over four rows
    for (int i = 0; i < 300; i++) begin
      logic [16:0] a;
      a = {6'd0, 2'($urandom % 4), 9'($urandom % 512)};
      if ($urandom % 40 == 0) do_refresh();
      do_req(1'($urandom % 2), a, 8'($urandom));
      if ($urandom % 25 == 0) repeat (ROW_OPEN_MAX) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    check(expq.size() == 0, "R6 all reads returned", expq.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule